// File: doc/BRIEF.md
# Half-Bridge Gate Control with Start-Up Fault Latch

This block is the digital control core of a synchronous buck power stage. It takes one PWM command, delivered as two digitized comparator flags, and produces enables for the high-side and low-side gate drivers. The two switches are never enabled in the same cycle. The dead time is adaptive: a switch is enabled only after the opposite switch is sensed off, and then only after a fixed, per-direction count of clock cycles. A PWM input that rests at the mid level long enough parks both switches off. Switching resumes only on a full-high level.

The block also supervises the stage. A bad supply, over-temperature or an external disable each turn both gates off. Before the first high-side turn-on, the block watches for a charged output: the soft-start flag and the switch-node flag both set. If it sees one, it latches a fault, holds the low-side switch on to discharge the output, and pulls the shared disable line low until the next reset. All inputs are asynchronous and pass through synchronizers. Missing gate-off feedback cannot hang the block: after a timeout both gates stay off until the PWM command changes.

Top module: `hb_gate_ctrl`

## Requirements
- R1: `hs_gate_o` and `ls_gate_o` are never both 1 in the same cycle.
- R2: A PWM rise is handled as follows. `ls_gate_o` falls 4 clock edges after the input change (two synchronizer stages, the command register, the gate register). If the low-side-off sense is already present, `hs_gate_o` rises DT_HS_CYC edges later. `hs_gate_o` never rises unless the low-side-off sense was seen in the previous cycle.
- R3: A PWM fall is handled as follows. `hs_gate_o` falls 4 edges after the input change. If high-side-off and switch-node-low are both already sensed, `ls_gate_o` rises DT_LS_CYC edges later. `ls_gate_o` never rises in normal operation without both senses present.
- R4: A synchronized mid level held for MID_HOLD_CYC consecutive cycles forces both gates off. A shorter mid level keeps the previous command.
- R5: After a mid-level shutdown, a return to low does not resume switching. Only a high level does.
- R6: When `supply_ok_i` is 0, both gates are off and `dis_pull_o` is 1. Switching resumes once the supply is good again.
- R7: When `dis_n_i` is 0, both gates are off and `dis_pull_o` is not raised by it. Switching resumes when the input returns to 1.
- R8: When `ovt_i` is 1, both gates are off and `dis_pull_o` is 1.
- R9: A start-up fault is declared if `ss_above_i` and `sw_above_i` are both 1 before the first high-side turn-on since reset. The fault latches until reset and forces `ls_gate_o`=1, `hs_gate_o`=0 and `dis_pull_o`=1, whatever the other inputs do.
- R10: After the first high-side turn-on, `ss_above_i` and `sw_above_i` no longer declare a fault.
- R11: Suppose the sense awaited before a turn-on stays missing for SENSE_TMO_CYC cycles. Both gates then stay off, even if the sense arrives later, until the PWM command changes.
- R12: PWM level encoding: `pwm_hi_i`=1 means high, whatever `pwm_lo_i` is. Otherwise `pwm_lo_i`=1 means low. With both flags 0 the level is mid.
- R13: During and right after reset, `hs_gate_o`=0, `ls_gate_o`=0 and `dis_pull_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| pwm_hi_i | input | 1 | PWM input above the high threshold |
| pwm_lo_i | input | 1 | PWM input below the low threshold |
| hs_off_i | input | 1 | High-side gate sensed off |
| ls_off_i | input | 1 | Low-side gate sensed off |
| sw_low_i | input | 1 | Switch node sensed low |
| supply_ok_i | input | 1 | Control supply above its lockout level |
| ovt_i | input | 1 | Over-temperature |
| ss_above_i | input | 1 | Soft-start level above its fault threshold |
| sw_above_i | input | 1 | Switch node above its start-up fault threshold |
| dis_n_i | input | 1 | Active-low disable, read from the shared line |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |
| dis_pull_o | output | 1 | Pull the shared disable line low |

## Verification
A PWM edge reaches the falling gate 4 edges after the input change. The rising gate follows after another DT_HS_CYC or DT_LS_CYC edges. Supply, over-temperature and disable changes settle within 4 edges; the mid shutdown takes MID_HOLD_CYC plus 3 edges. The exact-latency checks for R2 and R3 hold the sense inputs constant, so the sampled edges count only the synchronizers, the command register, the dead-time counter and the gate register. All other checks, including the random phases where the bench feeds the gates back as sense, sample only after a hold longer than the worst of these latencies plus the sense loop.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    CMD_LO  = 2'd0,
    CMD_HI  = 2'd1,
    CMD_OFF = 2'd2
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT_HS = 3'd1,
    ST_HS_ON   = 3'd2,
    ST_WAIT_LS = 3'd3,
    ST_LS_ON   = 3'd4,
    ST_HOLD    = 3'd5
  } phase_e;

  localparam int NUM_ASYNC = 10;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[gi] <= '0;
          else     stg[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[gi] <= '0;
          else     stg[gi] <= stg[gi-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/hb_pwm_decode.sv
module hb_pwm_decode
  import hb_pkg::*;
#(
  parameter int MID_HOLD_CYC = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic hi_s,
  input  logic lo_s,
  output cmd_e cmd_q
);

  localparam int MW = $clog2(MID_HOLD_CYC + 1);

  logic [MW-1:0] mcnt;
  logic          tri_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= CMD_OFF;
      tri_q <= 1'b0;
      mcnt  <= '0;
    end else if (hi_s) begin
      cmd_q <= CMD_HI;
      tri_q <= 1'b0;
      mcnt  <= '0;
    end else if (lo_s) begin
      mcnt  <= '0;
      cmd_q <= tri_q ? CMD_OFF : CMD_LO;
    end else if (tri_q) begin
      cmd_q <= CMD_OFF;
    end else if (mcnt == MW'(MID_HOLD_CYC - 1)) begin
      tri_q <= 1'b1;
      cmd_q <= CMD_OFF;
      mcnt  <= '0;
    end else begin
      mcnt <= mcnt + 1'b1;
    end
  end

  // R5
  mid_latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tri_q && !hi_s) |=> tri_q);

  // R5
  mid_latch_off_chk: assert property (@(posedge clk) disable iff (rst)
    (tri_q && !hi_s) |=> (cmd_q == CMD_OFF));

endmodule

// File: rtl/hb_fault.sv
module hb_fault (
  input  logic clk,
  input  logic rst,
  input  logic ss_s,
  input  logic swa_s,
  input  logic hs_on,
  output logic fault_q
);

  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
      fault_q <= 1'b0;
    end else begin
      if (hs_on) armed_q <= 1'b0;
      if (armed_q && !hs_on && ss_s && swa_s) fault_q <= 1'b1;
    end
  end

  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fault_q |=> fault_q);

  // R10
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !fault_q) |=> !fault_q);

endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
  import hb_pkg::*;
#(
  parameter int DT_HS_CYC     = 3,
  parameter int DT_LS_CYC     = 5,
  parameter int SENSE_TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  cmd_e cmd,
  input  logic run,
  input  logic force_ls,
  input  logic hs_off_s,
  input  logic ls_off_s,
  input  logic swlow_s,
  output logic hs_q,
  output logic ls_q
);

  localparam int DT_MAX = (DT_HS_CYC > DT_LS_CYC) ? DT_HS_CYC : DT_LS_CYC;
  localparam int DW     = $clog2(DT_MAX + 1);
  localparam int TW     = $clog2(SENSE_TMO_CYC + 1);

  phase_e        st, nxt;
  logic [DW-1:0] dcnt, dcnt_n;
  logic [TW-1:0] tcnt, tcnt_n;
  cmd_e          held, held_n;
  logic          hs_clear;

  assign hs_clear = hs_off_s && swlow_s;

  always_comb begin
    nxt    = st;
    dcnt_n = dcnt;
    tcnt_n = tcnt;
    held_n = held;
    if (force_ls || !run) begin
      nxt = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (cmd == CMD_HI)      nxt = ST_WAIT_HS;
          else if (cmd == CMD_LO) nxt = ST_WAIT_LS;
        end
        ST_WAIT_HS: begin
          if (cmd != CMD_HI) begin
            nxt = (cmd == CMD_LO) ? ST_WAIT_LS : ST_IDLE;
          end else if (!ls_off_s) begin
            dcnt_n = '0;
            if (tcnt == TW'(SENSE_TMO_CYC - 1)) begin
              nxt    = ST_HOLD;
              held_n = cmd;
            end else begin
              tcnt_n = tcnt + 1'b1;
            end
          end else if (dcnt == DW'(DT_HS_CYC - 1)) begin
            nxt = ST_HS_ON;
          end else begin
            dcnt_n = dcnt + 1'b1;
          end
        end
        ST_WAIT_LS: begin
          if (cmd != CMD_LO) begin
            nxt = (cmd == CMD_HI) ? ST_WAIT_HS : ST_IDLE;
          end else if (!hs_clear) begin
            dcnt_n = '0;
            if (tcnt == TW'(SENSE_TMO_CYC - 1)) begin
              nxt    = ST_HOLD;
              held_n = cmd;
            end else begin
              tcnt_n = tcnt + 1'b1;
            end
          end else if (dcnt == DW'(DT_LS_CYC - 1)) begin
            nxt = ST_LS_ON;
          end else begin
            dcnt_n = dcnt + 1'b1;
          end
        end
        ST_HS_ON: begin
          if (cmd != CMD_HI) nxt = (cmd == CMD_LO) ? ST_WAIT_LS : ST_IDLE;
        end
        ST_LS_ON: begin
          if (cmd != CMD_LO) nxt = (cmd == CMD_HI) ? ST_WAIT_HS : ST_IDLE;
        end
        ST_HOLD: begin
          if (cmd != held) nxt = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
    if (nxt != st) begin
      dcnt_n = '0;
      tcnt_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      dcnt <= '0;
      tcnt <= '0;
      held <= CMD_OFF;
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      st   <= nxt;
      dcnt <= dcnt_n;
      tcnt <= tcnt_n;
      held <= held_n;
      hs_q <= (nxt == ST_HS_ON) && !force_ls;
      ls_q <= force_ls || (nxt == ST_LS_ON);
    end
  end

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_q && ls_q));

  // R2
  hs_after_ls_off_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_q) |-> ($past(ls_off_s) && !$past(force_ls)));

  // R3
  ls_after_hs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_q) |-> ($past(force_ls) || $past(hs_clear)));

  // R7
  stop_gates_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !force_ls) |=> (!hs_q && !ls_q));

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int DT_HS_CYC     = 3,
  parameter int DT_LS_CYC     = 5,
  parameter int MID_HOLD_CYC  = 40,
  parameter int SENSE_TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_hi_i,
  input  logic pwm_lo_i,
  input  logic hs_off_i,
  input  logic ls_off_i,
  input  logic sw_low_i,
  input  logic supply_ok_i,
  input  logic ovt_i,
  input  logic ss_above_i,
  input  logic sw_above_i,
  input  logic dis_n_i,
  output logic hs_gate_o,
  output logic ls_gate_o,
  output logic dis_pull_o
);

  logic [NUM_ASYNC-1:0] raw, syn;
  logic hi_s, lo_s, hs_off_s, ls_off_s, swlow_s;
  logic sup_s, ovt_s, ss_s, swa_s, dis_n_s;
  logic fault_q, run;
  cmd_e cmd;

  assign raw = {pwm_hi_i, pwm_lo_i, hs_off_i, ls_off_i, sw_low_i,
                supply_ok_i, ovt_i, ss_above_i, sw_above_i, dis_n_i};

  hb_sync #(.W(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (syn)
  );

  assign {hi_s, lo_s, hs_off_s, ls_off_s, swlow_s,
          sup_s, ovt_s, ss_s, swa_s, dis_n_s} = syn;

  hb_pwm_decode #(.MID_HOLD_CYC(MID_HOLD_CYC)) u_dec (
    .clk   (clk),
    .rst   (rst),
    .hi_s  (hi_s),
    .lo_s  (lo_s),
    .cmd_q (cmd)
  );

  hb_fault u_fault (
    .clk     (clk),
    .rst     (rst),
    .ss_s    (ss_s),
    .swa_s   (swa_s),
    .hs_on   (hs_gate_o),
    .fault_q (fault_q)
  );

  assign run = sup_s && dis_n_s && !ovt_s;

  hb_deadtime #(
    .DT_HS_CYC     (DT_HS_CYC),
    .DT_LS_CYC     (DT_LS_CYC),
    .SENSE_TMO_CYC (SENSE_TMO_CYC)
  ) u_dt (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .run      (run),
    .force_ls (fault_q),
    .hs_off_s (hs_off_s),
    .ls_off_s (ls_off_s),
    .swlow_s  (swlow_s),
    .hs_q     (hs_gate_o),
    .ls_q     (ls_gate_o)
  );

  always_ff @(posedge clk) begin
    if (rst) dis_pull_o <= 1'b1;
    else     dis_pull_o <= fault_q || ovt_s || !sup_s;
  end

  // R9
  fault_pulls_chk: assert property (@(posedge clk) disable iff (rst)
    fault_q |=> (dis_pull_o && ls_gate_o && !hs_gate_o));

  // R8
  ovt_pulls_chk: assert property (@(posedge clk) disable iff (rst)
    ovt_s |=> dis_pull_o);

endmodule

// File: tb/tb_hb_gate_ctrl.sv
module tb_hb_gate_ctrl;

  localparam int DT_HS = 3;
  localparam int DT_LS = 5;
  localparam int MIDC  = 40;
  localparam int TMO   = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm_hi_i = 1'b0, pwm_lo_i = 1'b1;
  logic supply_ok_i = 1'b1, ovt_i = 1'b0, ss_above_i = 1'b0, sw_above_i = 1'b0;
  logic dis_n_i = 1'b1;
  logic fs = 1'b0, f_hs_off = 1'b1, f_ls_off = 1'b1, f_swl = 1'b1;
  logic hs_off_i, ls_off_i, sw_low_i;
  logic hs_gate_o, ls_gate_o, dis_pull_o;

  int n_chk = 0, n_fail = 0, overlap = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign hs_off_i = fs ? f_hs_off : ~hs_gate_o;
  assign ls_off_i = fs ? f_ls_off : ~ls_gate_o;
  assign sw_low_i = fs ? f_swl    : ~hs_gate_o;

  hb_gate_ctrl #(
    .SYNC_STAGES(2), .DT_HS_CYC(DT_HS), .DT_LS_CYC(DT_LS),
    .MID_HOLD_CYC(MIDC), .SENSE_TMO_CYC(TMO)
  ) dut (
    .clk(clk), .rst(rst), .pwm_hi_i(pwm_hi_i), .pwm_lo_i(pwm_lo_i),
    .hs_off_i(hs_off_i), .ls_off_i(ls_off_i), .sw_low_i(sw_low_i),
    .supply_ok_i(supply_ok_i), .ovt_i(ovt_i), .ss_above_i(ss_above_i),
    .sw_above_i(sw_above_i), .dis_n_i(dis_n_i),
    .hs_gate_o(hs_gate_o), .ls_gate_o(ls_gate_o), .dis_pull_o(dis_pull_o)
  );

  always @(negedge clk) if (!rst && hs_gate_o && ls_gate_o) overlap++;

  // expected {hs, ls, pull} for a settled level: 0 low, 1 mid-off, 2 high
  function automatic logic [2:0] exp_run(input int lvl);
    if (lvl == 2)      return 3'b100;
    else if (lvl == 0) return 3'b010;
    else               return 3'b000;
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {hs_gate_o, ls_gate_o, dis_pull_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: hs/ls/pull=%b expected %b", req, act, exp);
    end
  endtask

  task automatic set_pwm(input int lvl);
    pwm_hi_i = (lvl == 2);
    pwm_lo_i = (lvl == 0);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    // R13 reset state
    wait_n(5);
    check("R13", 3'b001);
    @(negedge clk) rst = 1'b0;
    check("R13", 3'b001);
    wait_n(25);
    check("R13", exp_run(0));

    // R2 / R3 exact latency with constant sense
    fs = 1'b1; f_hs_off = 1'b1; f_ls_off = 1'b1; f_swl = 1'b1;
    set_pwm(2);
    wait_n(3); check("R2", 3'b010);
    wait_n(1); check("R2", 3'b000);
    wait_n(DT_HS - 1); check("R2", 3'b000);
    wait_n(1); check("R2", 3'b100);
    set_pwm(0);
    wait_n(3); check("R3", 3'b100);
    wait_n(1); check("R3", 3'b000);
    wait_n(DT_LS - 1); check("R3", 3'b000);
    wait_n(1); check("R3", 3'b010);
    fs = 1'b0;

    // random levels with closed sense loop, short mid glitches
    for (int it = 0; it < 40; it++) begin
      int lvl;
      lvl = ($urandom_range(1, 0) == 1) ? 2 : 0;
      if ($urandom_range(3, 0) == 0) begin
        set_pwm(1);
        wait_n($urandom_range(20, 1));
      end
      set_pwm(lvl);
      wait_n($urandom_range(40, 25));
      check(lvl == 2 ? "R2" : "R3", exp_run(lvl));
    end

    // R4 / R5 mid level
    set_pwm(2); wait_n(30);
    set_pwm(1); wait_n(MIDC - 5);
    check("R4 short mid", 3'b100);
    set_pwm(2); wait_n(10);
    set_pwm(1); wait_n(MIDC + 20);
    check("R4 long mid", 3'b000);
    set_pwm(0); wait_n(30);
    check("R5 low no resume", 3'b000);
    set_pwm(2); wait_n(30);
    check("R5 high resumes", 3'b100);

    // R7 disable input
    dis_n_i = 1'b0; wait_n(10);
    check("R7", 3'b000);
    dis_n_i = 1'b1; wait_n(30);
    check("R7", 3'b100);

    // R6 supply
    supply_ok_i = 1'b0; wait_n(10);
    check("R6", 3'b001);
    supply_ok_i = 1'b1; wait_n(30);
    check("R6", 3'b100);

    // R8 over-temperature
    ovt_i = 1'b1; wait_n(10);
    check("R8", 3'b001);
    ovt_i = 1'b0; wait_n(30);
    check("R8", 3'b100);

    // R11 sense timeout
    fs = 1'b1; f_hs_off = 1'b1; f_swl = 1'b1; f_ls_off = 1'b1;
    set_pwm(0); wait_n(30);
    check("R11 setup", 3'b010);
    f_ls_off = 1'b0;
    set_pwm(2); wait_n(TMO + 30);
    check("R11 timeout", 3'b000);
    f_ls_off = 1'b1; wait_n(30);
    check("R11 late sense", 3'b000);
    set_pwm(0); wait_n(30);
    check("R11 edge resumes", 3'b010);
    fs = 1'b0;
    set_pwm(2); wait_n(30);
    check("R11", 3'b100);

    // R10 no fault after first high-side turn-on
    ss_above_i = 1'b1; sw_above_i = 1'b1; wait_n(20);
    check("R10", 3'b100);
    set_pwm(0); wait_n(30);
    check("R10", 3'b010);
    ss_above_i = 1'b0; sw_above_i = 1'b0;

    // R9 start-up fault
    rst = 1'b1; wait_n(5);
    ss_above_i = 1'b1; sw_above_i = 1'b1; set_pwm(0);
    rst = 1'b0; wait_n(20);
    check("R9", 3'b011);
    ss_above_i = 1'b0; sw_above_i = 1'b0;
    set_pwm(2); wait_n(40);
    check("R9 latched", 3'b011);
    dis_n_i = 1'b0; wait_n(20);
    check("R9 latched", 3'b011);
    dis_n_i = 1'b1;
    rst = 1'b1; wait_n(5);
    rst = 1'b0; wait_n(40);
    check("R9 reset clears", 3'b100);

    // R12 both flags high decode as high
    set_pwm(0); wait_n(30);
    pwm_hi_i = 1'b1; pwm_lo_i = 1'b1; wait_n(30);
    check("R12", 3'b100);

    // R1 overlap monitor
    n_chk++;
    if (overlap != 0) begin
      n_fail++;
      $display("FAIL R1: overlap cycles=%0d expected 0", overlap);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule